// File: doc/BRIEF.md
# Laser Driver Safety Fault Latch

This block guards the output stage of a laser driver. It watches two analog comparator results (bias-monitor overvoltage and photodiode overcurrent) as digital inputs. It also runs its own digital check on the bias DAC code: a fault is raised when a new code is less than half of the code applied before it. When fault detection is enabled, any of these causes sets a registered fault flag. The same clock edge forces the bias, modulation and peaking enables low.

The flag stays set until software or the host requests a recovery. A recovery request is the disable pin driven high or the register enable bit driven low, and it must be held for longer than a parameterised reset time. The disable pin passes through a synchronizer. Either disable source also gates the three enables in normal operation. Neither one clears the stored bias code. When every blocking condition is gone, the enables come back after a parameterised enable time. If a comparator fault is still present when the disable is released, the flag sets again at once.

Top module: `laser_fault_guard`

## Requirements
- R1: While reset is applied and on the first cycle after it, flt_o, bias_en_o, mod_en_o and peak_en_o are all 0.
- R2: With fault_en_i=1 and no off request, mon_ovr_i=1 in a cycle sets flt_o at the next rising edge, and the same edge drives all three enables to 0.
- R3: With fault_en_i=1 and no off request, pd_ovr_i=1 sets flt_o and clears the enables at the next rising edge.
- R4: On every cycle with bias_upd_i=1, the block compares bias_code_i with the previously applied code, which is 0 after reset. The block takes it as a step fault when bias_code_i < (previous >> 1), using an integer shift. It then stores bias_code_i as the applied code. With bias_upd_i=0 no comparison is made.
- R5: Once set, flt_o stays 1 after the fault cause goes away, until a recovery per R8.
- R6: With fault_en_i=0 no cause sets flt_o, and a faulting cycle does not clear the enables.
- R7: ena_bit_i=0 drives all enables to 0 at the next rising edge. dis_pin_i=1 passes a two-flop synchronizer and drives them to 0 at the third rising edge after it changes. Neither one alters the stored bias code.
- R8: An off request (synchronized DIS high or ENA low) held for more than RST_CYC consecutive cycles clears flt_o at the (RST_CYC+1)-th rising edge of the request, and flt_o stays 0 while the request is held. A request of RST_CYC cycles or fewer leaves flt_o set.
- R9: The enables return to 1 at the (EN_CYC+1)-th rising edge counted from the first cycle with no off request and flt_o=0.
- R10: If a comparator fault is still present when the off request ends, flt_o sets at the first rising edge without the request, and the enables stay 0.
- R11: bias_en_o, mod_en_o and peak_en_o always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dis_pin_i | input | 1 | Asynchronous disable pin, high = off |
| ena_bit_i | input | 1 | Register enable bit, low = off |
| fault_en_i | input | 1 | Fault detection enable |
| mon_ovr_i | input | 1 | Bias-monitor overvoltage comparator |
| pd_ovr_i | input | 1 | Photodiode overcurrent comparator |
| bias_code_i | input | CODE_W | Bias DAC code being applied |
| bias_upd_i | input | 1 | Strobe: bias_code_i is a new code this cycle |
| flt_o | output | 1 | Latched fault flag |
| bias_en_o | output | 1 | Bias current enable |
| mod_en_o | output | 1 | Modulation current enable |
| peak_en_o | output | 1 | Peaking current enable |

## Verification
Comparator, step and ENA effects register at the very next rising edge, so the bench drives on a falling edge and samples one falling edge later. DIS goes through two synchronizer flops before that register, so its effects are sampled on the third falling edge, and the bench also checks that nothing has moved on the second. The bench holds the recovery request for exactly RST_CYC cycles and for exactly RST_CYC+1 cycles to find the clear edge. It counts falling edges from release until the enables rise and compares that count with EN_CYC+1. The step rule is swept over every new code against a spread of previous codes, and each expected result is computed with the shift formula.

// File: rtl/laser_guard_pkg.sv
package laser_guard_pkg;

    localparam int unsigned LANES    = 3;
    localparam int unsigned LANE_BIAS = 0;
    localparam int unsigned LANE_MOD  = 1;
    localparam int unsigned LANE_PEAK = 2;

    typedef struct packed {
        logic             flt;
        logic [LANES-1:0] en;
    } guard_state_t;

endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/guard_hold_timer.sv
module guard_hold_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i)           cnt_d = '0;
        else if (cnt_q == TOP) cnt_d = cnt_q;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == TOP);
endmodule

// File: rtl/bias_step_check.sv
module bias_step_check #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              upd_i,
    output logic              drop_o
);
    logic [CODE_W-1:0] applied_d, applied_q;
    logic [CODE_W-1:0] half_prev;

    always_comb begin
        half_prev = applied_q >> 1;
        applied_d = upd_i ? code_i : applied_q;
        drop_o    = upd_i && (code_i < half_prev);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) applied_q <= '0;
        else         applied_q <= applied_d;
    end
endmodule

// File: rtl/laser_fault_guard.sv
module laser_fault_guard
    import laser_guard_pkg::*;
#(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned RST_CYC     = 16,
    parameter int unsigned EN_CYC      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dis_pin_i,
    input  logic              ena_bit_i,
    input  logic              fault_en_i,
    input  logic              mon_ovr_i,
    input  logic              pd_ovr_i,
    input  logic [CODE_W-1:0] bias_code_i,
    input  logic              bias_upd_i,
    output logic              flt_o,
    output logic              bias_en_o,
    output logic              mod_en_o,
    output logic              peak_en_o
);
    guard_state_t st_d, st_q;

    logic dis_s;
    logic off_req;
    logic step_drop;
    logic cause_now;
    logic set_now;
    logic clear_armed;
    logic block_now;
    logic on_ready;

    guard_sync #(.STAGES(SYNC_STAGES)) i_dis_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (dis_pin_i),
        .q_o   (dis_s)
    );

    bias_step_check #(.CODE_W(CODE_W)) i_step (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .code_i(bias_code_i),
        .upd_i (bias_upd_i),
        .drop_o(step_drop)
    );

    guard_hold_timer #(.LIMIT(RST_CYC)) i_off_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (off_req),
        .done_o(clear_armed)
    );

    guard_hold_timer #(.LIMIT(EN_CYC)) i_on_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (!block_now),
        .done_o(on_ready)
    );

    always_comb begin
        off_req   = dis_s || !ena_bit_i;
        cause_now = mon_ovr_i || pd_ovr_i || step_drop;
        set_now   = fault_en_i && cause_now && !clear_armed;
        block_now = off_req || st_q.flt || set_now;

        st_d = st_q;
        if (clear_armed)  st_d.flt = 1'b0;
        else if (set_now) st_d.flt = 1'b1;

        for (int unsigned k = 0; k < LANES; k++) begin
            st_d.en[k] = on_ready;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flt_o     = st_q.flt;
    assign bias_en_o = st_q.en[LANE_BIAS];
    assign mod_en_o  = st_q.en[LANE_MOD];
    assign peak_en_o = st_q.en[LANE_PEAK];
endmodule

// File: rtl/laser_fault_guard_chk.sv
module laser_fault_guard_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic fault_en_i,
    input logic mon_ovr_i,
    input logic pd_ovr_i,
    input logic off_req,
    input logic flt_o,
    input logic bias_en_o,
    input logic mod_en_o,
    input logic peak_en_o
);
    // R2, R3
    p_cmp_sets_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_en_i && (mon_ovr_i || pd_ovr_i) && !off_req) |=> flt_o);

    p_flag_forces_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_o |-> (!bias_en_o && !mod_en_o && !peak_en_o));

    p_latch_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flt_o && !off_req) |=> flt_o);

    p_ignored_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fault_en_i && !flt_o) |=> !flt_o);

    p_off_gates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        off_req |=> (!bias_en_o && !mod_en_o && !peak_en_o));

    p_lanes_equal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bias_en_o == mod_en_o) && (mod_en_o == peak_en_o));
endmodule

bind laser_fault_guard laser_fault_guard_chk i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_en_i(fault_en_i),
    .mon_ovr_i (mon_ovr_i),
    .pd_ovr_i  (pd_ovr_i),
    .off_req   (off_req),
    .flt_o     (flt_o),
    .bias_en_o (bias_en_o),
    .mod_en_o  (mod_en_o),
    .peak_en_o (peak_en_o)
);

// File: tb/test_laser_fault_guard.sv
module test_laser_fault_guard;
    localparam int RST = 6;
    localparam int ENC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dis = 1'b0, ena = 1'b0, fen = 1'b0, mon = 1'b0, pd = 1'b0, upd = 1'b0;
    logic [7:0] code = 8'd0;
    logic flt, ben, men, pen;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    laser_fault_guard #(.CODE_W(8), .RST_CYC(RST), .EN_CYC(ENC), .SYNC_STAGES(2)) i_laser_fault_guard (
        .clk_i(clk), .rst_ni(rst_n), .dis_pin_i(dis), .ena_bit_i(ena), .fault_en_i(fen),
        .mon_ovr_i(mon), .pd_ovr_i(pd), .bias_code_i(code), .bias_upd_i(upd),
        .flt_o(flt), .bias_en_o(ben), .mod_en_o(men), .peak_en_o(pen)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int ens();
        return (ben && men && pen) ? 1 : ((!ben && !men && !pen) ? 0 : 2);
    endfunction

    // ENA low for exactly RST+1 cycles, then released
    task automatic recover();
        ena = 1'b0;
        step(RST + 1);
        ena = 1'b1;
    endtask

    // wait for enables to rise, return falling edges counted
    task automatic count_up(output int n);
        n = 0;
        while (ens() != 1 && n < 50) begin
            step(1);
            n++;
        end
    endtask

    initial begin
        int n;
        step(3);
        chk("R1 flt in reset", flt, 0);
        chk("R1 en in reset", ens(), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 flt after reset", flt, 0);
        chk("R1 en after reset", ens(), 0);

        // R9 enable time from a clean start
        ena = 1'b1; fen = 1'b1;
        count_up(n);
        chk("R9 enable delay", n, ENC + 1);

        // R2 monitor fault
        mon = 1'b1; step(1); mon = 1'b0;
        chk("R2 flt on mon", flt, 1);
        chk("R2 en off on mon", ens(), 0);
        step(5);
        chk("R5 flt latched", flt, 1);
        chk("R11 lanes equal", ens(), 0);

        // R8 short request keeps latch
        ena = 1'b0; step(RST); ena = 1'b1; step(1);
        chk("R8 short hold keeps flt", flt, 1);
        // R8 exact clear edge
        ena = 1'b0;
        step(RST);
        chk("R8 still set at RST", flt, 1);
        step(1);
        chk("R8 clear at RST+1", flt, 0);
        step(3);
        chk("R8 low while held", flt, 0);
        ena = 1'b1;
        count_up(n);
        chk("R9 return after clear", n, ENC + 1);

        // R3 photodiode fault
        pd = 1'b1; step(1); pd = 1'b0;
        chk("R3 flt on pd", flt, 1);
        chk("R3 en off on pd", ens(), 0);
        recover();
        count_up(n);

        // R6 ignore
        fen = 1'b0; mon = 1'b1; pd = 1'b1; step(3);
        chk("R6 flt ignored", flt, 0);
        chk("R6 en kept", ens(), 1);
        mon = 1'b0; pd = 1'b0; fen = 1'b1;
        step(1);

        // R7 ENA gating
        ena = 1'b0; step(1);
        chk("R7 ena off", ens(), 0);
        chk("R7 ena no flt", flt, 0);
        ena = 1'b1; count_up(n);
        chk("R9 after ena", n, ENC + 1);

        // R7 DIS gating with synchronizer latency
        dis = 1'b1; step(2);
        chk("R7 dis not yet", ens(), 1);
        step(1);
        chk("R7 dis off 3rd edge", ens(), 0);
        dis = 1'b0; step(3);
        count_up(n);

        // R7 stored code kept across a disable, R4 drop
        fen = 1'b0; upd = 1'b1; code = 8'd200; step(1); upd = 1'b0;
        ena = 1'b0; step(4); ena = 1'b1; step(1);
        fen = 1'b1; upd = 1'b1; code = 8'd90; step(1); upd = 1'b0;
        chk("R7 code kept R4 drop", flt, 1);
        recover(); count_up(n);

        // R4 no strobe no check
        fen = 1'b0; upd = 1'b1; code = 8'd200; step(1); upd = 1'b0; fen = 1'b1;
        code = 8'd0; step(2);
        chk("R4 no strobe", flt, 0);

        // R10 persistent fault via DIS recovery
        mon = 1'b1; step(1);
        chk("R10 set", flt, 1);
        dis = 1'b1; step(2 + RST + 1);
        chk("R10 cleared under dis", flt, 0);
        dis = 1'b0; step(2);
        chk("R10 not yet", flt, 0);
        step(1);
        chk("R10 reassert", flt, 1);
        chk("R10 en stay off", ens(), 0);
        mon = 1'b0;
        recover(); count_up(n);

        // R4 sweep
        for (int old = 0; old < 256; old += 15) begin
            for (int nw = 0; nw < 256; nw++) begin
                fen = 1'b0; upd = 1'b1; code = 8'(old); step(1);
                fen = 1'b1; code = 8'(nw); step(1);
                upd = 1'b0; fen = 1'b0;
                chk($sformatf("R4 old=%0d new=%0d", old, nw), flt, (nw < (old >> 1)) ? 1 : 0);
                if (flt) recover();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule